// File: doc/BRIEF.md
# Presettable Binary Counter with Auto-Reload

A synchronous up counter of parameterized width (default 8 bits). A preset value can be loaded into it on a clock edge. It flags the all-ones state on an active-low terminal-count output. A mode input decides what happens at that state. With the mode low, the counter rolls over to zero and keeps running. With the mode high, the terminal count is fed back inside the block, so the counter reloads its preset instead of wrapping. The block then acts as a programmable divider with a period of 2^WIDTH minus the preset.

An asynchronous, active-high master clear forces the count to zero and the terminal count inactive. Count enable and load enable are both active low, and load takes priority over everything except the clear.

A wider counter is built by chaining stages. Each higher stage takes as its count enable the OR of the terminal counts of all lower stages. It therefore steps only on the edge at which every lower stage is at all ones, and the lower stages roll over on that same edge.

Top module: `presettable_counter`

## Requirements
- R1: While `clear_a` is high, `count` is all zeros and `term_n` is 1, at once and without waiting for a clock edge. The clear overrides every other input.
- R2: With `load_n` low, the rising clock edge copies `preset` into `count`, for any value of `cnt_en_n` and `reload_mode`.
- R3: With `load_n` high and `cnt_en_n` high, `count` keeps its value across the clock edge, also at all ones with `reload_mode` high.
- R4: With `load_n` high, `cnt_en_n` low and `count` not all ones, the rising clock edge adds one to `count`.
- R5: `term_n` is 0 exactly when every bit of `count` is 1, in the same cycle, with no register delay.
- R6: With `load_n` high, `cnt_en_n` low, `reload_mode` low and `count` all ones, the next edge makes `count` zero.
- R7: With `load_n` high, `cnt_en_n` low, `reload_mode` high and `term_n` low, the next edge loads `preset`. After a load of preset P, the terminal count first appears after 2^WIDTH-1-P edges and then repeats every 2^WIDTH-P edges.
- R8: Two stages, where the upper stage's `cnt_en_n` is the lower stage's `term_n`, count as one counter of twice the width. This includes the roll-over from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clear_a | input | 1 | Asynchronous master clear, active high |
| cnt_en_n | input | 1 | Count enable, active low |
| load_n | input | 1 | Parallel load enable, active low, highest synchronous priority |
| reload_mode | input | 1 | 1: reload preset at terminal count; 0: wrap to zero |
| preset | input | WIDTH | Parallel preset value |
| count | output | WIDTH | Current count |
| term_n | output | 1 | Terminal count, active low, low when count is all ones |

## Verification
Every preset from 0 to 255 is run in reload mode, and the spacing of the terminal counts is measured. A counter that reloads one edge late, or that reloads on the wrong state, shows an off-by-one period. A preset of 255 is the extreme case: a design that tests for roll-over instead of all ones would never reload there. Load is tried against all combinations of enable and mode, and hold is tried at all ones with the reload mode high, which catches a reload that ignores the enable. The clear is pulsed between clock edges to expose a reset that is really synchronous. A two-stage chain is pushed through its full roll-over, where a wrongly gated upper enable double-steps or misses the carry.

// File: rtl/pbc_pkg.sv
// Package: shared types of the presettable counter.
// Assumes: nothing beyond IEEE 1800-2017.
package pbc_pkg;

    // Action taken by the state register on the coming clock edge.
    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_INC    = 2'd1,
        ACT_PRESET = 2'd2
    } pbc_action_e;

endpackage

// File: rtl/pbc_ctrl.sv
// Module: pbc_ctrl
// Decides the next-edge action from the control inputs and the terminal count.
// Assumes: all inputs active low except reload_mode; load outranks counting.
module pbc_ctrl
    import pbc_pkg::*;
(
    input  logic        load_n,
    input  logic        cnt_en_n,
    input  logic        reload_mode,
    input  logic        term_n,
    output pbc_action_e action
);

    // Priority decode: load, then count (with optional reload), then hold.
    always_comb begin
        if (!load_n) begin
            action = ACT_PRESET;
        end else if (!cnt_en_n) begin
            if (reload_mode && !term_n) begin
                action = ACT_PRESET;
            end else begin
                action = ACT_INC;
            end
        end else begin
            action = ACT_HOLD;
        end
    end

endmodule

// File: rtl/pbc_next.sv
// Module: pbc_next
// Forms the next count value: hold, increment (natural wrap) or preset.
// Assumes: WIDTH >= 1; incrementer is a generated carry chain.
module pbc_next
    import pbc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  pbc_action_e      action,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] preset,
    output logic [WIDTH-1:0] nxt
);

    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] inc;

    assign carry[0] = 1'b1;

    // Ripple incrementer, one half-adder per bit; top carry-out is dropped.
    for (genvar i = 0; i < WIDTH; i++) begin : g_inc
        assign inc[i]     = cur[i] ^ carry[i];
        assign carry[i+1] = cur[i] & carry[i];
    end

    // Select the value presented to the state register.
    always_comb begin
        unique case (action)
            ACT_INC:    nxt = inc;
            ACT_PRESET: nxt = preset;
            default:    nxt = cur;
        endcase
    end

endmodule

// File: rtl/pbc_term.sv
// Module: pbc_term
// Combinational all-ones detector giving the active-low terminal count.
// Assumes: input is the registered count; no register added here.
module pbc_term #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] cur,
    output logic             term_n
);

    logic [WIDTH:0] ones;

    assign ones[0] = 1'b1;

    // AND chain across the bits.
    for (genvar i = 0; i < WIDTH; i++) begin : g_and
        assign ones[i+1] = ones[i] & cur[i];
    end

    assign term_n = ~ones[WIDTH];

endmodule

// File: rtl/pbc_state.sv
// Module: pbc_state
// Count register with asynchronous active-high master clear.
// Assumes: clear_a may change at any time relative to clk.
module pbc_state #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clear_a,
    input  logic [WIDTH-1:0] nxt,
    output logic [WIDTH-1:0] cur
);

    // Register the next value, cleared at once by the master clear.
    always_ff @(posedge clk or posedge clear_a) begin
        if (clear_a) begin
            cur <= '0;
        end else begin
            cur <= nxt;
        end
    end

    AST_CLEAR_ZEROES: assert property (@(posedge clk) clear_a |-> cur == '0); // R1

endmodule

// File: rtl/presettable_counter.sv
// Module: presettable_counter
// Presettable synchronous up counter with mode-gated terminal-count reload.
// Assumes: cascade by tying a higher stage's cnt_en_n to the OR of lower term_n.
module presettable_counter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clear_a,
    input  logic             cnt_en_n,
    input  logic             load_n,
    input  logic             reload_mode,
    input  logic [WIDTH-1:0] preset,
    output logic [WIDTH-1:0] count,
    output logic             term_n
);

    import pbc_pkg::*;

    pbc_action_e      action;
    logic [WIDTH-1:0] nxt;

    pbc_term #(.WIDTH(WIDTH)) u_term (
        .cur    (count),
        .term_n (term_n)
    );

    pbc_ctrl u_ctrl (
        .load_n      (load_n),
        .cnt_en_n    (cnt_en_n),
        .reload_mode (reload_mode),
        .term_n      (term_n),
        .action      (action)
    );

    pbc_next #(.WIDTH(WIDTH)) u_next (
        .action (action),
        .cur    (count),
        .preset (preset),
        .nxt    (nxt)
    );

    pbc_state #(.WIDTH(WIDTH)) u_state (
        .clk     (clk),
        .clear_a (clear_a),
        .nxt     (nxt),
        .cur     (count)
    );

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (clear_a)
        !load_n |=> count == $past(preset)); // R2
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (clear_a)
        (load_n && cnt_en_n) |=> $stable(count)); // R3
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (clear_a)
        (load_n && !cnt_en_n && term_n) |=> count == $past(count) + {{(WIDTH-1){1'b0}}, 1'b1}); // R4
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (clear_a)
        (load_n && !cnt_en_n && !term_n && !reload_mode) |=> count == '0); // R6
    AST_AUTO_RELOAD: assert property (@(posedge clk) disable iff (clear_a)
        (load_n && !cnt_en_n && !term_n && reload_mode) |=> count == $past(preset)); // R7
    AST_CLEAR_TERM_IDLE: assert property (@(posedge clk) clear_a |-> term_n); // R1

endmodule

// File: tb/sim_presettable_counter.sv
module sim_presettable_counter;

    logic       clk = 1'b0;
    logic       clear_a = 1'b1;
    logic       cnt_en_n = 1'b1;
    logic       load_n = 1'b1;
    logic       reload_mode = 1'b0;
    logic [7:0] preset = 8'h00;
    logic [7:0] count;
    logic       term_n;

    logic       c_en_n = 1'b1;
    logic       c_load_n = 1'b1;
    logic [7:0] c_pre_lo = 8'h00;
    logic [7:0] c_pre_hi = 8'h00;
    logic [7:0] c_lo, c_hi;
    logic       c_tlo, c_thi;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    logic [7:0]  exp8;
    logic [15:0] exp16;

    always #4 clk = ~clk;

    presettable_counter #(.WIDTH(8)) u0 (
        .clk(clk), .clear_a(clear_a), .cnt_en_n(cnt_en_n), .load_n(load_n),
        .reload_mode(reload_mode), .preset(preset), .count(count), .term_n(term_n)
    );

    presettable_counter #(.WIDTH(8)) u1 (
        .clk(clk), .clear_a(clear_a), .cnt_en_n(c_en_n), .load_n(c_load_n),
        .reload_mode(1'b0), .preset(c_pre_lo), .count(c_lo), .term_n(c_tlo)
    );

    presettable_counter #(.WIDTH(8)) u2 (
        .clk(clk), .clear_a(clear_a), .cnt_en_n(c_tlo | c_en_n), .load_n(c_load_n),
        .reload_mode(1'b0), .preset(c_pre_hi), .count(c_hi), .term_n(c_thi)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        int n;
        #1;
        // R1: clear state before any edge
        check("R1 count", {8'h0, count}, 16'h0);
        check("R1 term_n", {15'h0, term_n}, 16'h1);
        tick(); tick();
        clear_a = 1'b0;
        cnt_en_n = 1'b0;

        // R4 R5 R6: free run across two wraps
        exp8 = 8'h00;
        for (int i = 0; i < 520; i++) begin
            tick();
            exp8 = exp8 + 8'h01;
            check("R4/R6 count", {8'h0, count}, {8'h0, exp8});
            check("R5 term_n", {15'h0, term_n}, {15'h0, (exp8 != 8'hFF)});
        end

        // R3: hold, then hold at all ones with reload mode
        cnt_en_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tick();
            check("R3 hold", {8'h0, count}, {8'h0, exp8});
        end
        load_n = 1'b0; preset = 8'hFF; tick(); load_n = 1'b1;
        reload_mode = 1'b1; preset = 8'h12;
        for (int i = 0; i < 3; i++) begin
            tick();
            check("R3 hold at ones", {8'h0, count}, 16'h00FF);
            check("R5 term at ones", {15'h0, term_n}, 16'h0);
        end

        // R2: load wins in every enable/mode combination
        for (int k = 0; k < 4; k++) begin
            load_n = 1'b0;
            cnt_en_n = k[0];
            reload_mode = k[1];
            preset = 8'h3C + 8'(k * 37);
            tick();
            check("R2 load", {8'h0, count}, {8'h0, preset});
            preset = 8'hFF;
            tick();
            check("R2 load ones", {8'h0, count}, 16'h00FF);
        end
        load_n = 1'b1;

        // R1: asynchronous clear mid-count
        cnt_en_n = 1'b0; reload_mode = 1'b0;
        load_n = 1'b0; preset = 8'h77; tick(); load_n = 1'b1;
        tick(); tick();
        check("R4 pre-clear", {8'h0, count}, 16'h0079);
        #2 clear_a = 1'b1;
        #1;
        check("R1 async count", {8'h0, count}, 16'h0);
        check("R1 async term", {15'h0, term_n}, 16'h1);
        load_n = 1'b0; preset = 8'hFF;
        tick(); tick();
        check("R1 clear overrides load", {8'h0, count}, 16'h0);
        load_n = 1'b1;
        clear_a = 1'b0;
        tick();
        check("R1 release", {8'h0, count}, 16'h0001);

        // R7: reload sweep over every preset
        reload_mode = 1'b1;
        cnt_en_n = 1'b0;
        for (int p = 0; p < 256; p++) begin
            load_n = 1'b0; preset = 8'(p); tick(); load_n = 1'b1;
            n = 0;
            while (term_n && n < 300) begin tick(); n++; end
            check("R7 first term", 16'(n), 16'(255 - p));
            tick();
            check("R7 reload value", {8'h0, count}, 16'(p));
            n = 1;
            while (term_n && n < 300) begin tick(); n++; end
            check("R7 period", 16'(n), 16'(256 - p));
        end

        // R8: two-stage cascade through roll-over
        c_load_n = 1'b0; c_pre_lo = 8'h10; c_pre_hi = 8'hFE; tick(); c_load_n = 1'b1;
        exp16 = 16'hFE10;
        check("R8 cascade load", {c_hi, c_lo}, exp16);
        c_en_n = 1'b0;
        for (int i = 0; i < 600; i++) begin
            tick();
            exp16 = exp16 + 16'h1;
            check("R8 cascade", {c_hi, c_lo}, exp16);
        end
        c_en_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            check("R8 cascade hold", {c_hi, c_lo}, exp16);
        end

        finish_run();
    end

endmodule